// File: doc/BRIEF.md
# Fetch Decode-Mode Tracker

This block sits between the execute stage and the instruction fetch unit of a core that runs two instruction encodings: a standard 32-bit form on 4-byte boundaries and a dense 16-bit form on 2-byte boundaries. Each cycle the execute stage may present one resolved control transfer. The block gives back three things: the decode mode that applies from the next fetch onward, the aligned address to fetch from, and the return-link value that the register file should capture for a call.

Fetch addresses are always even, so bit 0 of an address carries no position information. This block uses that bit to record the mode. When a call is made, bit 0 of the link value records the caller's mode. When a jump goes through a register, its target's bit 0 selects the new mode and is then cleared. A return through the link register therefore restores the caller's mode with no separate mode stack. Some jump forms switch straight into dense mode: an absolute jump, an absolute call and a PC-relative call.

Every result is registered. The new mode, the new fetch address and a one-cycle redirect pulse all appear together on the cycle after the transfer is presented.

Top module: `fetch_mode_tracker`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the mode is standard (`dense_mode`=0), `fetch_pc` equals the parameter `RESET_VEC`, and `redirect_vld`, `link_we` and `align_fault` are low.
- R2: A transfer accepted on a clock edge (`xfer_valid`=1 with a kind that redirects) raises `redirect_vld` for exactly the following cycle. In that same cycle `fetch_pc` and `dense_mode` show the new values. Back-to-back transfers each produce their own redirect.
- R3: Kinds 0 (jump) and 1 (call) keep the current mode. The new `fetch_pc` is `xfer_tgt` with bit 0 cleared in dense mode, and with bits 1:0 cleared in standard mode.
- R4: Kinds 2 (register jump, used for return) and 3 (register call) take the new mode from `xfer_tgt[0]`. The new `fetch_pc` is `xfer_tgt` with bit 0 cleared.
- R5: A kind 2 or 3 whose `xfer_tgt[0]`=0 and `xfer_tgt[1]`=1 raises `align_fault` for one cycle. It does not raise `redirect_vld` or `link_we`, and it leaves `fetch_pc` and `dense_mode` unchanged. A target with both low bits set is not a fault.
- R6: Kinds 4 (mode-switching call) and 5 (mode-switching jump) set dense mode. The new `fetch_pc` is `xfer_tgt` with bit 0 cleared.
- R7: Kind 6 (PC-relative mode-switching call) sets dense mode. The new `fetch_pc` is `xfer_pc + xfer_tgt` (a two's-complement offset) with bit 0 cleared.
- R8: Kinds 1, 3, 4 and 6 pulse `link_we` together with `redirect_vld`. `link_val` is `xfer_pc` plus 2 if the caller was in dense mode, or plus 4 if it was in standard mode, and its bit 0 is set to the caller's mode.
- R9: With `xfer_valid` low, or with kind 7, nothing changes: `redirect_vld`, `link_we` and `align_fault` stay low, and `fetch_pc` and `dense_mode` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | A resolved transfer is presented this cycle |
| xfer_kind | input | 3 | Transfer kind, encoded 0 to 7 as listed in R3 to R9 |
| xfer_pc | input | AW | Address of the transfer instruction |
| xfer_tgt | input | AW | Absolute target, register value, or PC-relative offset for kind 6 |
| dense_mode | output | 1 | Current decode mode, 1 = dense |
| fetch_pc | output | AW | Aligned fetch address after the latest redirect |
| redirect_vld | output | 1 | One-cycle pulse: a new fetch address and mode apply |
| link_we | output | 1 | Write `link_val` to the link register |
| link_val | output | AW | Return address with the caller's mode in bit 0 |
| align_fault | output | 1 | One-cycle pulse: rejected misaligned standard-mode register target |

## Verification
The hardest case to reach is a call made while already in dense mode, followed by a register return that must bring back that caller's dense mode rather than standard mode. The stimulus therefore first enters dense mode through a mode-switching call, then makes an ordinary call inside dense code and returns through a target whose bit 0 is set. The misaligned-target fault is driven from both modes. The PC-relative form is given a negative offset so that the sum wraps below the instruction address.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [2:0] {
    XK_JMP      = 3'd0,
    XK_CALL     = 3'd1,
    XK_JREG     = 3'd2,
    XK_CALLREG  = 3'd3,
    XK_CALLX    = 3'd4,
    XK_JX       = 3'd5,
    XK_CALLXPC  = 3'd6,
    XK_NONE     = 3'd7
  } xfer_kind_e;

  typedef struct packed {
    logic take;   // redirect happens
    logic fault;  // misaligned register target
    logic link;   // link register written
    logic mode;   // mode after the transfer
  } xfer_dec_t;

endpackage

// File: rtl/fmt_decode.sv
module fmt_decode
  import fmt_pkg::*;
(
  input  logic       xfer_valid,
  input  xfer_kind_e kind,
  input  logic [1:0] tgt_lo,
  input  logic       cur_mode,
  output xfer_dec_t  dec
);

  logic reg_misaligned;

  always_comb begin
    reg_misaligned = (tgt_lo == 2'b10);
    dec = '{take: 1'b0, fault: 1'b0, link: 1'b0, mode: cur_mode};
    if (xfer_valid) begin
      case (kind)
        XK_JMP: dec.take = 1'b1;
        XK_CALL: begin
          dec.take = 1'b1;
          dec.link = 1'b1;
        end
        XK_JREG, XK_CALLREG: begin
          if (reg_misaligned) begin
            dec.fault = 1'b1;
          end else begin
            dec.take = 1'b1;
            dec.link = (kind == XK_CALLREG);
            dec.mode = tgt_lo[0];
          end
        end
        XK_CALLX, XK_CALLXPC: begin
          dec.take = 1'b1;
          dec.link = 1'b1;
          dec.mode = 1'b1;
        end
        XK_JX: begin
          dec.take = 1'b1;
          dec.mode = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fmt_target.sv
module fmt_target
  import fmt_pkg::*;
#(
  parameter int AW = 32
) (
  input  xfer_kind_e      kind,
  input  logic [AW-1:0]   xfer_pc,
  input  logic [AW-1:0]   xfer_tgt,
  input  logic            cur_mode,
  output logic [AW-1:0]   next_pc
);

  logic [AW-1:0] rel_sum;

  always_comb begin
    rel_sum = xfer_pc + xfer_tgt;
    case (kind)
      XK_JMP, XK_CALL:
        next_pc = cur_mode ? {xfer_tgt[AW-1:1], 1'b0}
                           : {xfer_tgt[AW-1:2], 2'b00};
      XK_CALLXPC:
        next_pc = {rel_sum[AW-1:1], 1'b0};
      default:
        next_pc = {xfer_tgt[AW-1:1], 1'b0};
    endcase
  end

endmodule

// File: rtl/fmt_link.sv
module fmt_link #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] xfer_pc,
  input  logic          cur_mode,
  output logic [AW-1:0] link_nxt
);

  localparam logic [AW-1:0] STEP_DENSE = AW'(2);
  localparam logic [AW-1:0] STEP_STD   = AW'(4);

  logic [AW-1:0] seq_pc;

  always_comb begin
    seq_pc   = xfer_pc + (cur_mode ? STEP_DENSE : STEP_STD);
    link_nxt = {seq_pc[AW-1:1], cur_mode};
  end

endmodule

// File: rtl/fmt_state.sv
module fmt_state
  import fmt_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = AW'('h1000)
) (
  input  logic          clk,
  input  logic          rst,
  input  xfer_dec_t     dec,
  input  logic [AW-1:0] next_pc,
  input  logic [AW-1:0] link_nxt,
  output logic          mode_q,
  output logic [AW-1:0] pc_q,
  output logic          redirect_q,
  output logic          link_we_q,
  output logic [AW-1:0] link_q,
  output logic          fault_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 1'b0;
      pc_q       <= RESET_VEC;
      redirect_q <= 1'b0;
      link_we_q  <= 1'b0;
      link_q     <= '0;
      fault_q    <= 1'b0;
    end else begin
      redirect_q <= dec.take;
      link_we_q  <= dec.take & dec.link;
      fault_q    <= dec.fault;
      if (dec.take) begin
        pc_q   <= next_pc;
        mode_q <= dec.mode;
      end
      if (dec.take && dec.link) begin
        link_q <= link_nxt;
      end
    end
  end

endmodule

// File: rtl/fetch_mode_tracker.sv
module fetch_mode_tracker
  import fmt_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = AW'('h1000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_valid,
  input  logic [2:0]    xfer_kind,
  input  logic [AW-1:0] xfer_pc,
  input  logic [AW-1:0] xfer_tgt,
  output logic          dense_mode,
  output logic [AW-1:0] fetch_pc,
  output logic          redirect_vld,
  output logic          link_we,
  output logic [AW-1:0] link_val,
  output logic          align_fault
);

  xfer_kind_e    kind;
  xfer_dec_t     dec;
  logic [AW-1:0] next_pc;
  logic [AW-1:0] link_nxt;

  assign kind = xfer_kind_e'(xfer_kind);

  fmt_decode u_dec (
    .xfer_valid (xfer_valid),
    .kind       (kind),
    .tgt_lo     (xfer_tgt[1:0]),
    .cur_mode   (dense_mode),
    .dec        (dec)
  );

  fmt_target #(.AW(AW)) u_tgt (
    .kind     (kind),
    .xfer_pc  (xfer_pc),
    .xfer_tgt (xfer_tgt),
    .cur_mode (dense_mode),
    .next_pc  (next_pc)
  );

  fmt_link #(.AW(AW)) u_lnk (
    .xfer_pc  (xfer_pc),
    .cur_mode (dense_mode),
    .link_nxt (link_nxt)
  );

  fmt_state #(.AW(AW), .RESET_VEC(RESET_VEC)) u_st (
    .clk        (clk),
    .rst        (rst),
    .dec        (dec),
    .next_pc    (next_pc),
    .link_nxt   (link_nxt),
    .mode_q     (dense_mode),
    .pc_q       (fetch_pc),
    .redirect_q (redirect_vld),
    .link_we_q  (link_we),
    .link_q     (link_val),
    .fault_q    (align_fault)
  );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          xfer_valid,
  input logic [2:0]    xfer_kind,
  input logic          dense_mode,
  input logic [AW-1:0] fetch_pc,
  input logic          redirect_vld,
  input logic          link_we,
  input logic [AW-1:0] link_val,
  input logic          align_fault
);

  a_r2_redirect_needs_xfer: assert property (@(posedge clk) disable iff (rst)
    redirect_vld |-> $past(xfer_valid));

  a_r4_pc_even: assert property (@(posedge clk) disable iff (rst)
    fetch_pc[0] == 1'b0);

  a_r3_std_word_aligned: assert property (@(posedge clk) disable iff (rst)
    !dense_mode |-> fetch_pc[1:0] == 2'b00);

  a_r5_fault_no_redirect: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> !redirect_vld && !link_we);

  a_r5_fault_holds_state: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> $stable(fetch_pc) && $stable(dense_mode));

  a_r6_switch_enters_dense: assert property (@(posedge clk) disable iff (rst)
    (redirect_vld && ($past(xfer_kind) inside {3'd4, 3'd5, 3'd6})) |-> dense_mode);

  a_r8_link_with_redirect: assert property (@(posedge clk) disable iff (rst)
    link_we |-> redirect_vld);

  a_r8_link_carries_mode: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_val[0] == $past(dense_mode));

  a_r9_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
    !redirect_vld |-> $stable(fetch_pc) && $stable(dense_mode));

  a_r9_kind7_inert: assert property (@(posedge clk) disable iff (rst)
    ($past(xfer_kind) == 3'd7) |-> !redirect_vld && !align_fault && !link_we);

endmodule

bind fetch_mode_tracker fmt_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .xfer_valid   (xfer_valid),
  .xfer_kind    (xfer_kind),
  .dense_mode   (dense_mode),
  .fetch_pc     (fetch_pc),
  .redirect_vld (redirect_vld),
  .link_we      (link_we),
  .link_val     (link_val),
  .align_fault  (align_fault)
);

// File: tb/sim_fetch_mode_tracker.sv
module sim_fetch_mode_tracker;

  localparam int          AW  = 32;
  localparam logic [31:0] RSV = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_valid = 1'b0;
  logic [2:0]    xfer_kind = 3'd7;
  logic [AW-1:0] xfer_pc = '0;
  logic [AW-1:0] xfer_tgt = '0;
  logic          dense_mode;
  logic [AW-1:0] fetch_pc;
  logic          redirect_vld;
  logic          link_we;
  logic [AW-1:0] link_val;
  logic          align_fault;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  bit          m_mode = 0;
  logic [31:0] m_pc   = RSV;
  bit          m_rv = 0, m_lwe = 0, m_flt = 0;
  logic [31:0] m_lv = '0;

  always #5 clk = ~clk;

  fetch_mode_tracker #(.AW(AW), .RESET_VEC(RSV)) u0 (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
    .xfer_pc(xfer_pc), .xfer_tgt(xfer_tgt), .dense_mode(dense_mode),
    .fetch_pc(fetch_pc), .redirect_vld(redirect_vld), .link_we(link_we),
    .link_val(link_val), .align_fault(align_fault)
  );

  task automatic chk(input string tag);
    checks++;
    if (dense_mode !== m_mode || fetch_pc !== m_pc || redirect_vld !== m_rv ||
        link_we !== m_lwe || align_fault !== m_flt || (m_lwe && link_val !== m_lv)) begin
      fails++;
      $display("FAIL %s: act mode=%0d pc=%h rv=%0d lwe=%0d lv=%h flt=%0d | exp mode=%0d pc=%h rv=%0d lwe=%0d lv=%h flt=%0d",
               tag, dense_mode, fetch_pc, redirect_vld, link_we, link_val, align_fault,
               m_mode, m_pc, m_rv, m_lwe, m_lv, m_flt);
    end
  endtask

  task automatic model(input bit v, input int k, input logic [31:0] p, input logic [31:0] t);
    bit newmode = m_mode;
    bit take = 0, lnk = 0;
    logic [31:0] npc = m_pc;
    m_rv = 0; m_lwe = 0; m_flt = 0;
    if (v) begin
      if (k == 0 || k == 1) begin
        take = 1; lnk = (k == 1);
        npc = m_mode ? (t & ~32'd1) : (t & ~32'd3);
      end else if (k == 2 || k == 3) begin
        if (t[0] == 0 && t[1] == 1) m_flt = 1;
        else begin take = 1; lnk = (k == 3); npc = t & ~32'd1; newmode = t[0]; end
      end else if (k == 4 || k == 5) begin
        take = 1; lnk = (k == 4); npc = t & ~32'd1; newmode = 1;
      end else if (k == 6) begin
        take = 1; lnk = 1; npc = (p + t) & ~32'd1; newmode = 1;
      end
    end
    if (take) begin
      m_rv = 1;
      if (lnk) begin
        m_lwe = 1;
        m_lv = ((p + (m_mode ? 32'd2 : 32'd4)) & ~32'd1) | {31'd0, m_mode};
      end
      m_pc = npc; m_mode = newmode;
    end
  endtask

  task automatic step(input bit v, input int k, input logic [31:0] p,
                      input logic [31:0] t, input string tag);
    @(negedge clk);
    xfer_valid = v; xfer_kind = 3'(k); xfer_pc = p; xfer_tgt = t;
    model(v, k, p, t);
    @(posedge clk);
    #1;
    chk(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R1 during reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1; chk("R1 after reset");

    step(1, 0, 32'h0000_1000, 32'h0000_2006, "R3 std jump drops bits 1:0");
    step(1, 1, 32'h0000_2004, 32'h0000_3000, "R8 std call link +4");
    step(1, 4, 32'h0000_3000, 32'h0000_4001, "R6 switch call into dense");
    step(1, 1, 32'h0000_4002, 32'h0000_5006, "R8 dense call link +2 bit0 set");
    step(1, 0, 32'h0000_5006, 32'h0000_5102, "R3 dense jump keeps bit 1");
    step(1, 2, 32'h0000_5102, 32'h0000_4005, "R4 return to dense caller");
    step(1, 2, 32'h0000_4004, 32'h0000_3004, "R4 return to std caller");
    step(1, 3, 32'h0000_3004, 32'h0000_6002, "R5 std-mode misaligned reg call");
    step(0, 0, 32'h0000_0000, 32'h0000_0000, "R5 state unchanged after fault");
    step(1, 5, 32'h0000_3004, 32'h0000_7003, "R6 switch jump into dense");
    step(1, 6, 32'h0000_7010, 32'hFFFF_FFF0, "R7 pc-relative negative offset");
    step(1, 2, 32'h0000_7000, 32'h0000_8802, "R5 misaligned reg jump from dense");
    step(1, 3, 32'h0000_7002, 32'h0000_8000, "R8 reg call dense to std");
    step(1, 7, 32'h0000_8000, 32'h0000_9000, "R9 kind 7 inert");
    step(0, 4, 32'h0000_8000, 32'h0000_9001, "R9 valid low inert");
    step(1, 2, 32'h0000_8000, 32'h0000_9003, "R5 both low bits set is no fault");
    step(1, 0, 32'h0000_9002, 32'h0000_A000, "R2 back-to-back first");
    step(1, 2, 32'h0000_A000, 32'h0000_B000, "R2 back-to-back second");
    step(0, 0, 32'h0000_0000, 32'h0000_0000, "R2 pulse ends");
    step(1, 3, 32'h0000_B000, 32'h0000_C001, "R4 reg call into dense");
    step(0, 0, 32'h0000_0000, 32'h0000_0000, "R9 idle hold");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule